// File: doc/BRIEF.md
# Dual-Oversampling Baud Tick Generator

This block turns one divisor register into the two timing strobes a UART needs. The receiver gets a sample strobe: 16 or 8 of them per bit. The transmitter gets a bit strobe. A single control bit picks the oversampling factor. In 16x mode the register holds the number of clocks in a bit period. In 8x mode the register holds a packed form of a divisor that is twice that large. The block unpacks this form itself.

The sample strobes are placed with a fractional accumulator. When the bit period is not a multiple of the oversampling factor, the remainder is spread across the bit. Every bit period is therefore exactly the divisor long, and the last sample strobe of a bit always coincides with the bit strobe. Dropping the enable, or giving a divisor below 16, parks the generator at the start of a bit. When it is allowed to run again, the first bit strobe comes one full bit period later. A typical setup is 115200 baud in 16x mode, with the register loaded with the clock frequency divided by the baud rate. That value is computed by software and is outside this block.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and before the first enabled clock, `sample_tick` and `bit_tick` are 0 and `sample_idx` is 0.
- R2: With `os_mode` = 0 (16x), the effective divisor D equals `div_reg` as written, and each bit period of D enabled clocks contains exactly 16 sample strobes.
- R3: With `os_mode` = 1 (8x), the effective divisor is D = {`div_reg`[15:4], `div_reg`[2:0], 1'b0}, and each bit period contains exactly 8 sample strobes.
- R4: Counting enabled rising edges from c = 1, `sample_tick` is high for one cycle after edge c exactly when floor(c·N/D) > floor((c−1)·N/D), where N is the oversampling factor. The strobes are therefore spread so that N of them span exactly D clocks.
- R5: `bit_tick` is high exactly after edges where c is a multiple of D, and only together with `sample_tick`. `sample_idx` equals floor(c·N/D) mod N, so it is 0 whenever `bit_tick` is high.
- R6: An effective divisor below 16 is invalid. While it is applied, no strobe is produced and `sample_idx` stays 0.
- R7: In 8x mode, a register with bit 3 set is invalid and is treated as in R6.
- R8: While `en` is low, both strobes are 0 and `sample_idx` is 0, and counting restarts. After `en` rises, the first `bit_tick` follows the D-th enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the counters |
| os_mode | input | 1 | Oversampling select: 0 = 16x, 1 = 8x |
| div_reg | input | DIV_W | Divisor register (packed form in 8x mode) |
| sample_tick | output | 1 | One-cycle receiver sample strobe |
| bit_tick | output | 1 | One-cycle bit-period strobe |
| sample_idx | output | 4 | Index of the next sample within the current bit |

## Verification
The bench first drives divisors that divide evenly: 16 in 16x mode, which gives a strobe on every clock, and 64. These give a fixed strobe spacing. It then drives divisors with remainders, 20 and 1000 in 16x mode and an 8x register that unpacks to 52. These give uneven spacing, and they separate a correct remainder-spreading accumulator from a plain integer divider. In 8x mode, a packed register whose naive and unpacked values differ shows whether the unpacking is done. Divisors of 15, an 8x value that unpacks to 14, and an 8x value with bit 3 set must yield silence. An enable drop in the middle of a bit must be followed by a full bit period before the next bit strobe.

// File: rtl/bg_pkg.sv
package bg_pkg;
   typedef enum logic {
      OS_X16 = 1'b0,
      OS_X8  = 1'b1
   } os_mode_e;

   localparam int unsigned MIN_DIV   = 16;
   localparam int unsigned STEP_W    = 5;
   localparam int unsigned IDX_W     = 4;
endpackage

// File: rtl/bg_div_decode.sv
module bg_div_decode
   import bg_pkg::*;
#(
   parameter int unsigned DIV_W  = 16,
   parameter bit          OS8_EN = 1'b1
) (
   input  logic [DIV_W-1:0]  div_reg,
   input  os_mode_e          mode,
   output logic [DIV_W-1:0]  eff_div,
   output logic [STEP_W-1:0] step,
   output logic              valid
);
   logic [DIV_W-1:0] packed_x8;
   logic             x8_sel;
   logic             fmt_ok;

   generate
      if (OS8_EN) begin : g_dual
         // rebuild the 8x divisor: high part kept, low nibble stored >>1
         assign packed_x8 = {div_reg[DIV_W-1:4], div_reg[2:0], 1'b0};
         assign x8_sel    = (mode == OS_X8);
         assign fmt_ok    = !(x8_sel && div_reg[3]);
      end else begin : g_x16_only
         assign packed_x8 = div_reg;
         assign x8_sel    = 1'b0;
         assign fmt_ok    = 1'b1;
      end
   endgenerate

   always_comb begin
      eff_div = x8_sel ? packed_x8 : div_reg;
      step    = x8_sel ? STEP_W'(8) : STEP_W'(16);
      valid   = fmt_ok && (eff_div >= DIV_W'(MIN_DIV));
   end
endmodule

// File: rtl/bg_frac_accum.sv
module bg_frac_accum
   import bg_pkg::*;
#(
   parameter int unsigned DIV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [STEP_W-1:0] step,
   input  logic [DIV_W-1:0]  div,
   output logic              hit
);
   localparam int unsigned SUM_W = DIV_W + 1;

   logic [DIV_W-1:0] acc_q;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] wrapped;

   always_comb begin
      sum     = {1'b0, acc_q} + SUM_W'(step);
      hit     = run && (sum >= {1'b0, div});
      wrapped = sum - {1'b0, div};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (!run) begin
         acc_q <= '0;
      end else if (hit) begin
         acc_q <= wrapped[DIV_W-1:0];
      end else begin
         acc_q <= sum[DIV_W-1:0];
      end
   end

   // R6: residue must stay below the divisor while running
   p_acc_below_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (acc_q < div) || $changed(div));
endmodule

// File: rtl/bg_phase_count.sv
module bg_phase_count
   import bg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              hit,
   input  logic [STEP_W-1:0] step,
   output logic              sample_tick,
   output logic              bit_tick,
   output logic [IDX_W-1:0]  sample_idx
);
   logic [IDX_W-1:0] last_idx;
   logic             at_end;

   always_comb begin
      last_idx = IDX_W'(step - STEP_W'(1));
      at_end   = (sample_idx >= last_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_tick <= 1'b0;
         bit_tick    <= 1'b0;
         sample_idx  <= '0;
      end else if (!run) begin
         sample_tick <= 1'b0;
         bit_tick    <= 1'b0;
         sample_idx  <= '0;
      end else begin
         sample_tick <= hit;
         bit_tick    <= hit && at_end;
         if (hit) begin
            sample_idx <= at_end ? '0 : sample_idx + IDX_W'(1);
         end
      end
   end

   // R5: a bit strobe is always also a sample strobe
   p_bit_needs_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick);
   // R5: the index is back at zero whenever a bit ends
   p_idx_zero_at_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> (sample_idx == '0));
   // R8: a stopped generator is silent and parked on the next edge
   p_quiet_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!sample_tick && !bit_tick && sample_idx == '0));
   // R4: the index only moves on a sample strobe
   p_idx_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !hit) |=> $stable(sample_idx));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import bg_pkg::*;
#(
   parameter int unsigned DIV_W  = 16,
   parameter bit          OS8_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             os_mode,
   input  logic [DIV_W-1:0] div_reg,
   output logic             sample_tick,
   output logic             bit_tick,
   output logic [3:0]       sample_idx
);
   generate
      if (DIV_W < 5) begin : g_bad_width
         $error("baud_tick_gen: DIV_W must hold the minimum divisor of 16");
      end
   endgenerate

   logic [DIV_W-1:0]  eff_div;
   logic [STEP_W-1:0] step;
   logic              div_ok;
   logic              run;
   logic              hit;
   os_mode_e          mode;

   assign mode = os_mode_e'(os_mode);
   assign run  = en && div_ok;

   bg_div_decode #(.DIV_W(DIV_W), .OS8_EN(OS8_EN)) u_decode (
      .div_reg (div_reg),
      .mode    (mode),
      .eff_div (eff_div),
      .step    (step),
      .valid   (div_ok)
   );

   bg_frac_accum #(.DIV_W(DIV_W)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .step  (step),
      .div   (eff_div),
      .hit   (hit)
   );

   bg_phase_count u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .hit         (hit),
      .step        (step),
      .sample_tick (sample_tick),
      .bit_tick    (bit_tick),
      .sample_idx  (sample_idx)
   );

   // R6 / R7: an invalid register leaves the strobes silent on the next edge
   p_invalid_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !div_ok |=> !sample_tick);
   // R7: 8x form with bit 3 set is never accepted
   p_x8_bit3_rejected_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (OS8_EN && os_mode && div_reg[3]) |-> !div_ok);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        os_mode = 1'b0;
   logic [15:0] div_reg = 16'd115;
   logic        sample_tick;
   logic        bit_tick;
   logic [3:0]  sample_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   baud_tick_gen u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .os_mode     (os_mode),
      .div_reg     (div_reg),
      .sample_tick (sample_tick),
      .bit_tick    (bit_tick),
      .sample_idx  (sample_idx)
   );

   task automatic report(string tag, int c, int a_s, int a_b, int a_i,
                         int e_s, int e_b, int e_i);
      n_chk++;
      if (a_s != e_s || a_b != e_b || a_i != e_i) begin
         n_bad++;
         if (n_bad <= 20)
            $display("FAIL %s c=%0d actual s=%0d b=%0d i=%0d expected s=%0d b=%0d i=%0d",
                     tag, c, a_s, a_b, a_i, e_s, e_b, e_i);
      end
   endtask

   // enable at a negedge, then compare every cycle against floor(cN/D)
   task automatic stream(string tag, logic [15:0] r, logic m, int d, int n, int cycles);
      en = 1'b0; div_reg = r; os_mode = m;
      @(negedge clk);
      en = 1'b1;
      for (int c = 1; c <= cycles; c++) begin
         int e_s, e_b, e_i;
         @(posedge clk); @(negedge clk);
         e_s = ((c * n) / d) != (((c - 1) * n) / d);
         e_b = (c % d) == 0;
         e_i = ((c * n) / d) % n;
         report(tag, c, sample_tick, bit_tick, sample_idx, e_s, e_b, e_i);
      end
   endtask

   task automatic silent(string tag, logic [15:0] r, logic m, int cycles);
      en = 1'b0; div_reg = r; os_mode = m;
      @(negedge clk);
      en = 1'b1;
      for (int c = 1; c <= cycles; c++) begin
         @(posedge clk); @(negedge clk);
         report(tag, c, sample_tick, bit_tick, sample_idx, 0, 0, 0);
      end
      en = 1'b0;
   endtask

   task automatic t_reset();
      report("R1 reset", 0, sample_tick, bit_tick, sample_idx, 0, 0, 0);
   endtask

   task automatic t_x16_even();
      stream("R2 x16 D=16", 16'd16, 1'b0, 16, 16, 48);
      stream("R2 x16 D=64", 16'd64, 1'b0, 64, 16, 130);
   endtask

   task automatic t_x16_spread();
      stream("R4 x16 D=20", 16'd20, 1'b0, 20, 16, 62);
      stream("R4 x16 D=1000", 16'd1000, 1'b0, 1000, 16, 2010);
   endtask

   task automatic t_x8_unpack();
      // intended 0x35 -> stored 0x32 -> effective 0x34 = 52
      stream("R3 x8 reg=0x32", 16'h0032, 1'b1, 52, 8, 160);
      // stored 0x0150 -> effective 0x0150 (low bits zero)
      stream("R3 x8 reg=0x150", 16'h0150, 1'b1, 336, 8, 680);
   endtask

   task automatic t_invalid();
      silent("R6 x16 D=15", 16'd15, 1'b0, 40);
      silent("R6 x8 unpacks to 14", 16'h0007, 1'b1, 40);
      silent("R7 x8 bit3 set", 16'h0048, 1'b1, 40);
   endtask

   task automatic t_restart();
      stream("R8 before drop", 16'd24, 1'b0, 24, 16, 30);
      en = 1'b0;
      for (int c = 1; c <= 3; c++) begin
         @(posedge clk); @(negedge clk);
         report("R8 disabled", c, sample_tick, bit_tick, sample_idx, 0, 0, 0);
      end
      stream("R8 after restart", 16'd24, 1'b0, 24, 16, 50);
      en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_x16_even();
      t_x16_spread();
      t_x8_unpack();
      t_invalid();
      t_restart();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule